// File: doc/BRIEF.md
# Single-Instruction Subtract Processor

This core runs programs built from one operation, subtraction. An instruction word has no opcode field. It holds only two address fields, A and B. Executing it replaces the word at B with the word at B minus the word at A. Every working register sits in one address space with the data: the program counter, an input port, an output port and a constant-zero word. A jump is therefore an ordinary subtraction whose destination is the program counter. Input and output are ordinary subtractions that read or write the port addresses.

A branch on a condition works as follows. When a result is written to the program counter, its least significant bit is replaced by a stored sign flag. The flag holds the sign of the most recent subtraction whose destination was not the program counter. Control then lands on one of two adjacent words. The first word of that pair usually holds a jump.

While reset is held, and after it until a start pulse, the core stays idle and a preload port writes program and data words. After the start pulse it fetches from address 0. It runs a fixed four-state sequence for every instruction and never stops by itself. A program ends by parking itself in a jump loop.

Top module: `sn_core`

## Requirements
- R1: After reset the core is idle with the program counter at 0, `out_data` = 0, `out_valid` = 0 and the sign flag = 0.
- R2: Each 16-bit instruction word carries A in bits [15:8] and B in bits [7:0]. Executing it stores (mem[B] - mem[A]) mod 2^16 into B.
- R3: A start pulse seen while idle starts execution at address 0. Every instruction takes exactly four cycles (fetch, read A, read B, write). The write of the n-th executed instruction happens on the 4n-th rising edge after the edge that sampled start. A write to B = 0xFD updates `out_data` on that edge and raises `out_valid` for exactly one cycle.
- R4: When B = 0xFF (the program counter), the new PC is bits [7:1] of the result with bit 0 replaced by the sign flag. For any other B the PC advances by one. Reading 0xFF returns the address of the executing instruction.
- R5: The sign flag takes bit 15 of each result whose destination is not 0xFF. A result written to 0xFF leaves the flag unchanged.
- R6: Reading 0xFE returns `in_data`. A write to 0xFE stores nothing and has no effect on later results.
- R7: Reading 0xFC returns 0. A write to 0xFC stores nothing.
- R8: Reading 0xFD returns the value last written to the output register.
- R9: Three subtractions through a zero-initialised scratch word (T-=X, T-=Y, OUT-=T, starting from OUT=0) deliver X+Y mod 2^16 on the output.
- R10: While the core is idle, `pl_we` stores `pl_data` at `pl_addr` for any address below 0xFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins execution when idle |
| pl_we | input | 1 | Preload write enable, honoured only while idle |
| pl_addr | input | 8 | Preload word address |
| pl_data | input | 16 | Preload word |
| in_data | input | 16 | Value returned by reads of the input port |
| out_data | output | 16 | Output port register |
| out_valid | output | 1 | One-cycle strobe when the output register is written |

## Verification
Each output item is due on an exact edge: 4n rising edges after the start edge, where n is the position of the writing instruction in the executed stream. This counts jumps and branch landings, so a taken or untaken branch moves the due edge by a multiple of four. The driver pushes each expected value together with its due edge into a scoreboard queue. The monitor samples at the falling clock edge, pops an item at every `out_valid`, and compares both the value and the elapsed edge count. Once a program has parked, the queue must be empty. Any strobe that arrives with no item queued is a failure.

// File: rtl/sn_pkg.sv
package sn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RDA   = 3'd2,
    ST_RDB   = 3'd3,
    ST_WRITE = 3'd4
  } sn_state_e;

  // mapped locations, counted down from the top of the address space
  localparam int OFS_PC   = 1;
  localparam int OFS_IN   = 2;
  localparam int OFS_OUT  = 3;
  localparam int OFS_ZERO = 4;
endpackage

// File: rtl/sn_space.sv
module sn_space
  import sn_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ok,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] pc_val,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] A_PC   = AW'(DEPTH - OFS_PC);
  localparam logic [AW-1:0] A_IN   = AW'(DEPTH - OFS_IN);
  localparam logic [AW-1:0] A_OUT  = AW'(DEPTH - OFS_OUT);
  localparam logic [AW-1:0] A_ZERO = AW'(DEPTH - OFS_ZERO);

  logic [DW-1:0] mem_q [DEPTH];

  function automatic logic is_plain(input logic [AW-1:0] a);
    return a < A_ZERO;
  endfunction

  // single write port shared by the loader and the sequencer
  logic          load_hit;
  logic          mem_we;
  logic [AW-1:0] mem_wa;
  logic [DW-1:0] mem_wd;
  logic          out_hit;

  assign load_hit = load_ok && pl_we;
  assign mem_wa   = wr_en ? wr_addr : pl_addr;
  assign mem_wd   = wr_en ? wr_data : pl_data;
  assign mem_we   = (wr_en || load_hit) && is_plain(mem_wa);
  assign out_hit  = wr_en && (wr_addr == A_OUT);

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= out_hit;
      if (out_hit) out_data <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr == A_PC)        rd_data = DW'(pc_val);
    else if (rd_addr == A_IN)   rd_data = in_data;
    else if (rd_addr == A_OUT)  rd_data = out_data;
    else if (rd_addr == A_ZERO) rd_data = '0;
    else                        rd_data = mem_q[rd_addr];
  end

  // R8: output register only moves on a write to its address
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hit |=> $stable(out_data));
endmodule

// File: rtl/sn_seq.sv
module sn_seq
  import sn_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] pc_q,
  output logic          idle,
  output logic          in_write
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] A_PC = AW'(DEPTH - OFS_PC);

  function automatic logic [DW-1:0] f_diff(input logic [DW-1:0] minuend,
                                           input logic [DW-1:0] subtrahend);
    return minuend - subtrahend;
  endfunction

  function automatic logic [AW-1:0] f_target(input logic [AW-2:0] hi,
                                             input logic flag);
    return {hi, flag};
  endfunction

  sn_state_e     state_q;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] opa_q;
  logic [DW-1:0] opb_q;
  logic          flag_q;

  logic [AW-1:0] fld_a;
  logic [AW-1:0] fld_b;
  logic [DW-1:0] diff;
  logic          dst_pc;
  logic [AW-1:0] pc_next;

  assign fld_a    = ir_q[2*AW-1:AW];
  assign fld_b    = ir_q[AW-1:0];
  assign diff     = f_diff(opb_q, opa_q);
  assign dst_pc   = (fld_b == A_PC);
  assign pc_next  = dst_pc ? f_target(diff[AW-1:1], flag_q) : pc_q + AW'(1);
  assign idle     = (state_q == ST_IDLE);
  assign in_write = (state_q == ST_WRITE);
  assign wr_en    = in_write && !dst_pc;
  assign wr_addr  = fld_b;
  assign wr_data  = diff;

  always_comb begin
    case (state_q)
      ST_RDA:  rd_addr = fld_a;
      ST_RDB:  rd_addr = fld_b;
      default: rd_addr = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ir_q    <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:  if (start) state_q <= ST_FETCH;
        ST_FETCH: begin
          ir_q    <= rd_data;
          state_q <= ST_RDA;
        end
        ST_RDA: begin
          opa_q   <= rd_data;
          state_q <= ST_RDB;
        end
        ST_RDB: begin
          opb_q   <= rd_data;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          pc_q    <= pc_next;
          if (!dst_pc) flag_q <= diff[DW-1];
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: fixed four-state order
  p_fetch_to_rda_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FETCH |=> state_q == ST_RDA);
  p_rdb_to_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_RDB |=> state_q == ST_WRITE);
  // R4: plain destination steps the PC by one
  p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_write && !dst_pc) |=> pc_q == $past(pc_q) + AW'(1));
  // R5: a PC destination leaves the flag alone
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_write && dst_pc) |=> $stable(flag_q));
  // R4: the PC only changes at the end of a write step
  p_pc_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_write |=> $stable(pc_q));
endmodule

// File: rtl/sn_core.sv
module sn_core
  import sn_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] pc_val;
  logic          idle;
  logic          in_write;

  sn_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pc_q     (pc_val),
    .idle     (idle),
    .in_write (in_write)
  );

  sn_space #(.DW(DW), .AW(AW)) u_space (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ok   (idle),
    .pl_we     (pl_we),
    .pl_addr   (pl_addr),
    .pl_data   (pl_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pc_val    (pc_val),
    .in_data   (in_data),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  // R3: a strobe always follows a write step and lasts one cycle
  p_strobe_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_write));
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R10: a running core ignores the preload port
  p_run_no_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_write |=> !idle);
endmodule

// File: tb/sn_core_tb.sv
module sn_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pl_we = 1'b0;
  logic [7:0]  pl_addr = '0;
  logic [15:0] pl_data = '0;
  logic [15:0] in_data = '0;
  logic [15:0] out_data;
  logic        out_valid;

  always #2 clk = ~clk;

  sn_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pl_we(pl_we),
    .pl_addr(pl_addr), .pl_data(pl_data), .in_data(in_data),
    .out_data(out_data), .out_valid(out_valid)
  );

  localparam logic [7:0] PCA = 8'hFF, INA = 8'hFE, OUTA = 8'hFD, ZRA = 8'hFC;
  localparam logic [7:0] M1 = 8'h43;

  typedef struct {
    int          due;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   n_chk = 0;
  int   n_fail = 0;
  int   edge_cnt = 0;
  int   start_edge = 0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per strobe
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 unexpected strobe", int'(out_data), 0);
      end else begin
        cur = sb.pop_front();
        check(out_data == cur.val, cur.tag, int'(out_data), int'(cur.val));
        check(edge_cnt - start_edge == cur.due, {cur.tag, " R3 timing"},
              edge_cnt - start_edge, cur.due);
      end
    end
  end

  function automatic logic [15:0] enc(input logic [7:0] a, input logic [7:0] b);
    return {a, b};
  endfunction

  task automatic push(input int due, input logic [15:0] val, input string tag);
    exp_t e;
    e.due = due; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic go_and_drain(input string tag);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start_edge = edge_cnt;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    check(sb.size() == 0, {tag, " all results seen"}, sb.size(), 0);
    sb.delete();
  endtask

  // R9 R2 R10: addition through three subtractions
  task automatic run_add(input logic [15:0] x, input logic [15:0] y);
    do_reset();
    load(8'h00, enc(8'h40, 8'h42));
    load(8'h01, enc(8'h41, 8'h42));
    load(8'h02, enc(8'h42, OUTA));
    load(8'h03, enc(M1, PCA));
    load(8'h04, enc(ZRA, PCA));
    load(8'h05, enc(ZRA, PCA));
    load(8'h40, x);
    load(8'h41, y);
    load(8'h42, 16'h0000);
    load(M1, 16'hFFFF);
    push(12, x + y, "R9 R2 R10 sum");
    go_and_drain("R9");
  endtask

  // R4 R5 R6: branch on the sign of the input word
  task automatic run_branch(input logic [15:0] v);
    logic neg;
    neg = v[15];
    do_reset();
    in_data = v;
    load(8'h00, enc(ZRA, INA));
    load(8'h01, enc(8'h44, PCA));
    load(8'h08, enc(8'h45, PCA));
    load(8'h09, enc(8'h51, OUTA));
    load(8'h0A, enc(M1, PCA));
    load(8'h0C, enc(8'h50, OUTA));
    load(8'h0D, enc(M1, PCA));
    load(8'h0E, enc(M1, PCA));
    load(M1, 16'hFFFF);
    load(8'h44, 16'hFFF9);
    load(8'h45, 16'hFFFC);
    load(8'h50, 16'hFFFE);
    load(8'h51, 16'hFFFF);
    if (neg) push(12, 16'h0001, "R4 R5 negative path");
    else     push(16, 16'h0002, "R4 R5 non-negative path");
    go_and_drain("R4");
  endtask

  // R6 R7 R8: mapped port writes ignored, output read back
  task automatic run_ports();
    do_reset();
    in_data = 16'h0003;
    load(8'h00, enc(M1, ZRA));
    load(8'h01, enc(M1, INA));
    load(8'h02, enc(ZRA, 8'h46));
    load(8'h03, enc(8'h46, OUTA));
    load(8'h04, enc(INA, OUTA));
    load(8'h05, enc(M1, PCA));
    load(8'h06, enc(ZRA, PCA));
    load(8'h07, enc(ZRA, PCA));
    load(M1, 16'hFFFF);
    load(8'h46, 16'h0005);
    push(16, 16'hFFFB, "R7 zero write ignored");
    push(20, 16'hFFF8, "R6 R8 input and readback");
    go_and_drain("R6");
  endtask

  initial begin
    do_reset();
    repeat (4) @(negedge clk);
    check(out_data == 16'h0000, "R1 reset out_data", int'(out_data), 0);
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    run_add(16'h1234, 16'h0101);
    run_add(16'hFFFF, 16'h0002);
    run_branch(16'h8001);
    run_branch(16'h7FFF);
    run_branch(16'h0000);
    run_ports();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule